// File: doc/BRIEF.md
# Zero-Substitution Line Decoder with Bipolar Violation Flag

This block sits behind a clock-recovery front end. It takes retimed dual-rail bipolar data, one bit for each cycle in which `bit_en` is high, and returns the same two rails after a fixed delay. When `zcs_en` is high it finds zero-substitution code words and puts all zeros on the output rails in their place. In B8ZS mode (`hdb3_mode` low) the code word is eight bits long. In HDB3 mode (`hdb3_mode` high) there are two code words, each four bits long. On the same cycle as each outgoing bit, a violation flag reports marks that break alternate-mark polarity.

Each incoming bit is a two-bit symbol written as {positive rail, negative rail}: 00 is a zero, 10 is a positive mark, 01 is a negative mark, and 11 is a double pulse. A polarity tracker follows the last mark that left the pipeline. It has three states: SEEN_NONE (no mark since reset), SEEN_POS and SEEN_NEG. On an enabled bit, a positive mark or a double pulse takes any state to SEEN_POS. A negative mark takes any state to SEEN_NEG. A zero, or a cycle with `bit_en` low, keeps the current state. Code-word polarity is judged against this state, so V means a mark of the same polarity as the tracked mark and B means a mark of the opposite polarity. In HDB3 mode with substitution enabled, the flag carries no defined meaning.

Top module: `bipolar_zs_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all three outputs are low, and the tracker is in SEEN_NONE.
- R2: A bit reaches the outputs 8 enabled bits after entry in B8ZS mode and 4 enabled bits after entry in HDB3 mode. The delay is the same whether `zcs_en` is high or low, and the outputs are low until the first input bit arrives.
- R3: With `zcs_en` low, the output rails repeat the input rails exactly, except that a double pulse (11) leaves as a positive mark (10).
- R4: In B8ZS mode with `zcs_en` high, the eight-bit sequence 0,0,0,V,B,0,B,V (oldest bit first) leaves as eight zeros.
- R5: In HDB3 mode with `zcs_en` high, the sequences 0,0,0,V and B,0,0,V leave as four zeros. In B,0,0,V, the final V has the same polarity as the B.
- R6: A code word is recognised only when some mark has left since reset. A sequence that appears in SEEN_NONE passes unchanged.
- R7: `bpv_out` is high for the same bit period as an outgoing mark whose polarity equals the tracked mark. The first mark after reset is never flagged.
- R8: In B8ZS mode, the two violations inside a replaced code word raise no flag. With `zcs_en` low, the same bits are flagged.
- R9: A double pulse leaves as a positive mark with `bpv_out` high, moves the tracker to SEEN_POS, and never forms part of a code word.
- R10: While `bit_en` is low, nothing advances, the inputs are ignored, and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High for one cycle for each line bit |
| pos_in | input | 1 | Positive input rail |
| neg_in | input | 1 | Negative input rail |
| hdb3_mode | input | 1 | 0 selects B8ZS rules, 1 selects HDB3 rules |
| zcs_en | input | 1 | 1 replaces recognised code words with zeros |
| pos_out | output | 1 | Positive output rail |
| neg_out | output | 1 | Negative output rail |
| bpv_out | output | 1 | Bipolar violation flag for the outgoing bit |

## Verification
On every cycle the assertions check three things. The outputs hold while `bit_en` is low. A flag is never raised without a mark. The flag agrees with output-side polarity alternation whenever the output stream keeps that alternation, which is everywhere except HDB3 substitution. Only the bench can show the exact contents and positions of the code words. It also covers the delay in each mode, patterns that appear before any mark and patterns that miss by one symbol, and the handling of double pulses. To do this, it drives every four-symbol word plus single-symbol corruptions of every code word and compares the result against a sequence-level model.

// File: rtl/zs_pkg.sv
package zs_pkg;
    // two-bit line symbol: {positive rail, negative rail}
    localparam logic [1:0] SYM_ZERO = 2'b00;
    localparam logic [1:0] SYM_POS  = 2'b10;
    localparam logic [1:0] SYM_NEG  = 2'b01;
    localparam logic [1:0] SYM_BOTH = 2'b11;

    localparam int CW_B8_LEN  = 8;
    localparam int CW_HDB_LEN = 4;

    typedef enum logic [1:0] {
        SEEN_NONE = 2'd0,
        SEEN_POS  = 2'd1,
        SEEN_NEG  = 2'd2
    } mark_t;
endpackage

// File: rtl/zs_delay_line.sv
module zs_delay_line #(
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic [1:0]            din,
    output logic [DEPTH-1:0][1:0] taps
);
    localparam int SR_W = 2 * DEPTH;

    logic [SR_W-1:0] sr;

    // newest symbol enters at the top, tap 0 is the oldest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (adv) begin
            sr <= {din, sr[SR_W-1:2]};
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        assign taps[k] = sr[2*k +: 2];
    end
endmodule

// File: rtl/zs_polarity_fsm.sv
module zs_polarity_fsm
    import zs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [1:0] head,
    output mark_t      prev,
    output logic       viol
);
    mark_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= SEEN_NONE;
        end else if (adv) begin
            prev <= nxt;
        end
    end

    always_comb begin
        unique case (prev)
            SEEN_NONE: begin
                nxt  = head[1] ? SEEN_POS : (head[0] ? SEEN_NEG : SEEN_NONE);
                viol = (head == SYM_BOTH);
            end
            SEEN_POS: begin
                nxt  = head[1] ? SEEN_POS : (head[0] ? SEEN_NEG : SEEN_POS);
                viol = head[1];
            end
            SEEN_NEG: begin
                nxt  = head[1] ? SEEN_POS : (head[0] ? SEEN_NEG : SEEN_NEG);
                viol = (head == SYM_NEG) || (head == SYM_BOTH);
            end
            default: begin
                nxt  = SEEN_NONE;
                viol = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/zs_matcher.sv
module zs_matcher
    import zs_pkg::*;
(
    input  logic [CW_B8_LEN-1:0][1:0] win,
    input  logic                      hdb3_mode,
    input  mark_t                     prev,
    output logic                      hit
);
    localparam int H0 = CW_B8_LEN - CW_HDB_LEN;

    logic [1:0] v_sym;
    logic [1:0] b_sym;
    logic       have;
    logic       b8_hit;
    logic       hdb_hit;

    always_comb begin
        have  = (prev != SEEN_NONE);
        v_sym = (prev == SEEN_POS) ? SYM_POS : SYM_NEG;
        b_sym = (prev == SEEN_POS) ? SYM_NEG : SYM_POS;

        b8_hit = have
            && win[0] == SYM_ZERO && win[1] == SYM_ZERO && win[2] == SYM_ZERO
            && win[3] == v_sym    && win[4] == b_sym
            && win[5] == SYM_ZERO && win[6] == b_sym    && win[7] == v_sym;

        hdb_hit = have
            && win[H0+1] == SYM_ZERO && win[H0+2] == SYM_ZERO
            && ((win[H0] == SYM_ZERO && win[H0+3] == v_sym)
             || (win[H0] == b_sym    && win[H0+3] == b_sym));

        hit = hdb3_mode ? hdb_hit : b8_hit;
    end
endmodule

// File: rtl/bipolar_zs_decoder.sv
module bipolar_zs_decoder
    import zs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic pos_in,
    input  logic neg_in,
    input  logic hdb3_mode,
    input  logic zcs_en,
    output logic pos_out,
    output logic neg_out,
    output logic bpv_out
);
    localparam int H0    = CW_B8_LEN - CW_HDB_LEN;
    localparam int CNT_W = $clog2(CW_B8_LEN);

    logic [CW_B8_LEN-1:0][1:0] win;
    logic [1:0]                head;
    mark_t                     prev;
    logic                      viol;
    logic                      hit;
    logic                      hit_ok;
    logic                      squash;
    logic [CNT_W-1:0]          blank_left;

    zs_delay_line #(.DEPTH(CW_B8_LEN)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (bit_en),
        .din  ({pos_in, neg_in}),
        .taps (win)
    );

    assign head = hdb3_mode ? win[H0] : win[0];

    zs_polarity_fsm u_pol (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (bit_en),
        .head (head),
        .prev (prev),
        .viol (viol)
    );

    zs_matcher u_match (
        .win      (win),
        .hdb3_mode(hdb3_mode),
        .prev     (prev),
        .hit      (hit)
    );

    assign hit_ok = zcs_en && (blank_left == '0) && hit;
    assign squash = zcs_en && (hit_ok || (blank_left != '0));

    // bits still to blank after the head of a recognised word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_left <= '0;
        end else if (bit_en) begin
            if (!zcs_en) begin
                blank_left <= '0;
            end else if (hit_ok) begin
                blank_left <= hdb3_mode ? CNT_W'(CW_HDB_LEN - 1) : CNT_W'(CW_B8_LEN - 1);
            end else if (blank_left != '0) begin
                blank_left <= blank_left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_out <= 1'b0;
            neg_out <= 1'b0;
            bpv_out <= 1'b0;
        end else if (bit_en) begin
            pos_out <= !squash && head[1];
            neg_out <= !squash && (head == SYM_NEG);
            bpv_out <= !squash && viol;
        end
    end
endmodule

// File: rtl/zs_decoder_chk.sv
module zs_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic hdb3_mode,
    input logic zcs_en,
    input logic pos_out,
    input logic neg_out,
    input logic bpv_out
);
    logic en_q;
    logic last_pos;
    logic last_neg;
    logic irregular;
    logic mode_q;
    logic zcs_q;
    logic regular;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            last_pos  <= 1'b0;
            last_neg  <= 1'b0;
            irregular <= 1'b0;
            mode_q    <= hdb3_mode;
            zcs_q     <= zcs_en;
        end else begin
            en_q   <= bit_en;
            mode_q <= hdb3_mode;
            zcs_q  <= zcs_en;
            if ((hdb3_mode && zcs_en) || hdb3_mode != mode_q || zcs_en != zcs_q)
                irregular <= 1'b1;
            if (bit_en && pos_out) begin
                last_pos <= 1'b1;
                last_neg <= 1'b0;
            end else if (bit_en && neg_out) begin
                last_pos <= 1'b0;
                last_neg <= 1'b1;
            end
        end
    end

    assign regular = !irregular && !(hdb3_mode && zcs_en)
                     && hdb3_mode == mode_q && zcs_en == zcs_q;

    // R10
    stable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({pos_out, neg_out, bpv_out}));

    // R7
    bpv_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_out |-> (pos_out || neg_out));

    // R7
    neg_repeat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && regular && neg_out && last_neg) |-> bpv_out);

    // R7
    neg_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && regular && neg_out && bpv_out) |-> last_neg);

    // R9
    pos_repeat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && regular && pos_out && last_pos) |-> bpv_out);
endmodule

bind bipolar_zs_decoder zs_decoder_chk u_zs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .hdb3_mode(hdb3_mode),
    .zcs_en   (zcs_en),
    .pos_out  (pos_out),
    .neg_out  (neg_out),
    .bpv_out  (bpv_out)
);

// File: tb/test_bipolar_zs_decoder.sv
`timescale 1ns/1ps
module test_bipolar_zs_decoder;
    localparam int MAXS = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic pos_in = 1'b0;
    logic neg_in = 1'b0;
    logic hdb3_mode = 1'b0;
    logic zcs_en = 1'b0;
    logic pos_out, neg_out, bpv_out;

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 1'b0;

    // symbol codes: 0 zero, 1 positive, 2 negative, 3 both rails
    int stim [MAXS];
    bit exp_p [MAXS];
    bit exp_n [MAXS];
    bit exp_b [MAXS];
    bit exp_s [MAXS];
    int n_sym;

    always #10 clk = ~clk;

    bipolar_zs_decoder i_bipolar_zs_decoder (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .pos_in(pos_in), .neg_in(neg_in),
        .hdb3_mode(hdb3_mode), .zcs_en(zcs_en),
        .pos_out(pos_out), .neg_out(neg_out), .bpv_out(bpv_out)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%b expected=%b (pos,neg,bpv)", req, act, exp);
        end
    endtask

    task automatic push(input int s);
        stim[n_sym] = s;
        n_sym++;
    endtask

    function automatic int sym_at(input int i);
        return (i < n_sym) ? stim[i] : 0;
    endfunction

    task automatic build_stream();
        int cw8 [8];
        int cwh [4];
        n_sym = 0;
        // R6: pattern shapes before any mark
        push(0); push(0); push(0); push(1); push(2); push(0); push(2); push(1);
        for (int w = 0; w < 256; w++)
            for (int d = 0; d < 4; d++) push((w >> (2 * d)) & 3);
        for (int p = 1; p <= 2; p++) begin
            cw8 = '{0, 0, 0, p, 3 - p, 0, 3 - p, p};
            push(p);
            for (int j = 0; j < 8; j++) push(cw8[j]);
            for (int j = 0; j < 8; j++)
                for (int a = 0; a < 4; a++)
                    if (a != cw8[j]) begin
                        push(p);
                        for (int q = 0; q < 8; q++) push(q == j ? a : cw8[q]);
                        push(0);
                    end
            for (int form = 0; form < 2; form++) begin
                cwh = (form == 0) ? '{0, 0, 0, p} : '{3 - p, 0, 0, 3 - p};
                push(p);
                for (int j = 0; j < 4; j++) push(cwh[j]);
                for (int j = 0; j < 4; j++)
                    for (int a = 0; a < 4; a++)
                        if (a != cwh[j]) begin
                            push(p);
                            for (int q = 0; q < 4; q++) push(q == j ? a : cwh[q]);
                            push(0);
                        end
            end
        end
    endtask

    task automatic build_expect(input bit hdb, input bit zcs);
        int last = 0;
        int blank = 0;
        int len = hdb ? 4 : 8;
        for (int i = 0; i < n_sym; i++) begin
            int s = stim[i];
            int pv = last;
            int bv = 3 - last;
            bit hit = 1'b0;
            bit viol;
            if (zcs && blank == 0 && last != 0) begin
                if (!hdb)
                    hit = sym_at(i) == 0 && sym_at(i+1) == 0 && sym_at(i+2) == 0 &&
                          sym_at(i+3) == pv && sym_at(i+4) == bv && sym_at(i+5) == 0 &&
                          sym_at(i+6) == bv && sym_at(i+7) == pv;
                else
                    hit = sym_at(i+1) == 0 && sym_at(i+2) == 0 &&
                          ((sym_at(i) == 0 && sym_at(i+3) == pv) ||
                           (sym_at(i) == bv && sym_at(i+3) == bv));
            end
            if (hit) blank = len;
            exp_s[i] = (blank > 0);
            if (blank > 0) blank--;
            viol = (s == 3) || (s == 1 && last == 1) || (s == 2 && last == 2);
            exp_p[i] = !exp_s[i] && (s == 1 || s == 3);
            exp_n[i] = !exp_s[i] && (s == 2);
            exp_b[i] = !exp_s[i] && viol;
            if (s == 1 || s == 3) last = 1;
            else if (s == 2) last = 2;
        end
    endtask

    task automatic run_config(input bit hdb, input bit zcs);
        int lat = hdb ? 4 : 8;
        logic [2:0] held;
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; hdb3_mode = hdb; zcs_en = zcs;
        pos_in = 1'b1; neg_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {pos_out, neg_out, bpv_out}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {pos_out, neg_out, bpv_out}, 3'b000);
        build_stream();
        build_expect(hdb, zcs);
        for (int k = 0; k < n_sym + lat; k++) begin
            int s = (k < n_sym) ? stim[k] : 0;
            int idx = k - lat;
            pos_in = (s == 1 || s == 3);
            neg_in = (s == 2 || s == 3);
            bit_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            bit_en = 1'b0;
            if (idx < 0) begin
                chk("R2 leading zeros", {pos_out, neg_out, bpv_out}, 3'b000);
            end else begin
                string lbl;
                logic [2:0] e = {exp_p[idx], exp_n[idx], exp_b[idx]};
                logic [2:0] a = {pos_out, neg_out, bpv_out};
                if (hdb && zcs) a[0] = e[0];
                if (idx < 8) lbl = "R6";
                else if (exp_s[idx]) lbl = hdb ? "R5" : "R4 R8";
                else if (stim[idx] == 3) lbl = "R9";
                else if (exp_b[idx]) lbl = zcs ? "R7" : "R7 R8";
                else if (!zcs) lbl = "R3";
                else lbl = "R2";
                chk(lbl, a, e);
            end
            if (k % 5 == 4) begin
                held = {pos_out, neg_out, bpv_out};
                pos_in = 1'b1; neg_in = 1'b1;
                repeat (2) begin
                    @(negedge clk);
                    chk("R10 hold", {pos_out, neg_out, bpv_out}, held);
                end
            end
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        run_config(1'b0, 1'b0);
        run_config(1'b0, 1'b1);
        run_config(1'b1, 1'b0);
        run_config(1'b1, 1'b1);
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errs++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end
endmodule